// File: doc/BRIEF.md
# Stereo Weighted Crossfade Mixer

This block blends two stereo streams, a reverse-played pair and a forward-played pair, into one stereo output. The blend uses a 16-bit unsigned weight. Each channel takes the reverse sample times the weight, adds the forward sample times the bitwise complement of the weight, and keeps the top 16 bits of the sum. Both channels of a frame use the same weight. The weight sequence comes from elsewhere. The block applies whatever weight it is given with each frame.

When the blend is switched off, the block does no arithmetic on the output. It passes one source straight through, picked by a playback-direction flag: the reverse pair while reverse playback is active, the forward pair otherwise. Every frame is presented with a one-cycle input strobe. The result appears two clock cycles later, together with a one-cycle output strobe. A new frame may be accepted on every cycle.

Top module: `xfade_mixer`

## Requirements
- R1: With `xfade_en`=1, each channel output equals floor((rev·w + fwd·(0xFFFF − w)) / 65536). The samples are signed two's-complement and `weight` is unsigned.
- R2: The left and right channels of one frame use the same `weight`, and each channel mixes only its own samples.
- R3: A weight of 0xFFFF gives floor(rev·65535/65536), which is nearly pure reverse. A weight of 0x0000 gives floor(fwd·65535/65536), which is nearly pure forward.
- R4: With `xfade_en`=0 and `rev_play`=1, each output equals its reverse sample exactly.
- R5: With `xfade_en`=0 and `rev_play`=0, each output equals its forward sample exactly.
- R6: Negative samples are sign-correct. Products keep the sign through the upper bits, and the shift rounds toward minus infinity.
- R7: The output never wraps. When rev equals fwd on a channel, the output lies in [rev−1, rev] for any weight, including full-scale positive and negative samples.
- R8: `out_valid` pulses exactly two cycles after each `in_valid` cycle, and at no other time.
- R9: The outputs keep their value in every cycle in which `out_valid` is low.
- R10: While `rst_n` is low, `out_valid` and both outputs are 0.
- R11: Frames strobed on consecutive cycles each produce their own result on consecutive cycles. Consecutive frames may use different modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame strobe; captures all inputs |
| xfade_en | input | 1 | 1 = blend the two sources, 0 = pass one source through |
| rev_play | input | 1 | Pass-through source select: 1 = reverse, 0 = forward |
| weight | input | 16 | Unsigned reverse weight; the forward weight is its complement |
| rev_l | input | 16 | Reverse left sample, signed |
| rev_r | input | 16 | Reverse right sample, signed |
| fwd_l | input | 16 | Forward left sample, signed |
| fwd_r | input | 16 | Forward right sample, signed |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| mix_l | output | 16 | Left result, signed |
| mix_r | output | 16 | Right result, signed |

## Verification
Two things can land on the same clock edge. One is the capture of a new frame into the product stage. The other is the completion of the previous frame in the output stage. The two frames may also be in different modes. The bench provokes this by strobing three frames back to back: a blended frame, a reverse pass-through frame and a forward pass-through frame. It then checks each output cycle against the value it computes for the frame strobed two cycles earlier. A stale mode flag or a stage enable tied to the wrong strobe shows up as a result that belongs to the neighbouring frame.

// File: rtl/xfm_pkg.sv
package xfm_pkg;
  // source chosen for a frame; decoded once at the block edge
  typedef enum logic [1:0] {
    SRC_FWD = 2'd0,
    SRC_REV = 2'd1,
    SRC_MIX = 2'd2
  } src_e;
endpackage

// File: rtl/xfm_vpipe.sv
module xfm_vpipe #(
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           v_in,
  output logic [LAT-1:0] v_stage
);
  logic [LAT-1:0] v_d;
  logic [LAT-1:0] v_q;

  always_comb begin
    v_d = {v_q[LAT-2:0], v_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  assign v_stage = v_q;
endmodule

// File: rtl/xfm_lane.sv
module xfm_lane
  import xfm_pkg::*;
#(
  parameter int DW = 16,
  parameter int WW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_a,
  input  logic                 ld_b,
  input  src_e                 src,
  input  logic signed [DW-1:0] rev,
  input  logic signed [DW-1:0] fwd,
  input  logic        [WW-1:0] w,
  output logic signed [DW-1:0] y
);
  localparam int PW = DW + WW + 1;
  localparam int SW = PW + 1;

  logic signed [PW-1:0] rev_x, fwd_x, w_x, wc_x;
  logic signed [PW-1:0] prod_rev_d, prod_fwd_d, prod_rev_q, prod_fwd_q;
  logic signed [DW-1:0] pass_d, pass_q;
  src_e                 src_q;
  logic signed [SW-1:0] sum;
  logic signed [DW-1:0] mix_val, y_d, y_q;
  logic                 unused_sum;

  // stage A: signed-by-unsigned products, sign kept in the upper bits
  always_comb begin
    rev_x      = {{(PW-DW){rev[DW-1]}}, rev};
    fwd_x      = {{(PW-DW){fwd[DW-1]}}, fwd};
    w_x        = {{(PW-WW){1'b0}}, w};
    wc_x       = {{(PW-WW){1'b0}}, ~w};
    prod_rev_d = rev_x * w_x;
    prod_fwd_d = fwd_x * wc_x;
    pass_d     = (src == SRC_REV) ? rev : fwd;
  end

  // stage B: accumulate, drop WW fraction bits (floor), or pass through
  always_comb begin
    sum     = {prod_rev_q[PW-1], prod_rev_q} + {prod_fwd_q[PW-1], prod_fwd_q};
    mix_val = sum[DW+WW-1:WW];
    y_d     = (src_q == SRC_MIX) ? mix_val : pass_q;
  end

  assign unused_sum = ^{sum[WW-1:0], sum[SW-1:DW+WW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_rev_q <= '0;
      prod_fwd_q <= '0;
      pass_q     <= '0;
      src_q      <= SRC_FWD;
      y_q        <= '0;
    end else begin
      if (ld_a) begin
        prod_rev_q <= prod_rev_d;
        prod_fwd_q <= prod_fwd_d;
        pass_q     <= pass_d;
        src_q      <= src;
      end
      if (ld_b) begin
        y_q <= y_d;
      end
    end
  end

  assign y = y_q;
endmodule

// File: rtl/xfade_mixer.sv
module xfade_mixer
  import xfm_pkg::*;
#(
  parameter int DW = 16,
  parameter int WW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 xfade_en,
  input  logic                 rev_play,
  input  logic        [WW-1:0] weight,
  input  logic signed [DW-1:0] rev_l,
  input  logic signed [DW-1:0] rev_r,
  input  logic signed [DW-1:0] fwd_l,
  input  logic signed [DW-1:0] fwd_r,
  output logic                 out_valid,
  output logic signed [DW-1:0] mix_l,
  output logic signed [DW-1:0] mix_r
);
  localparam int NCH = 2;
  localparam int LAT = 2;

  src_e                 src;
  logic [LAT-1:0]       v_stage;
  logic signed [DW-1:0] rev_a [NCH];
  logic signed [DW-1:0] fwd_a [NCH];
  logic signed [DW-1:0] y_a   [NCH];

  always_comb begin
    if (xfade_en)      src = SRC_MIX;
    else if (rev_play) src = SRC_REV;
    else               src = SRC_FWD;
  end

  assign rev_a[0] = rev_l;
  assign rev_a[1] = rev_r;
  assign fwd_a[0] = fwd_l;
  assign fwd_a[1] = fwd_r;

  xfm_vpipe #(.LAT(LAT)) u_vpipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .v_in    (in_valid),
    .v_stage (v_stage)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    xfm_lane #(.DW(DW), .WW(WW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_a  (in_valid),
      .ld_b  (v_stage[0]),
      .src   (src),
      .rev   (rev_a[c]),
      .fwd   (fwd_a[c]),
      .w     (weight),
      .y     (y_a[c])
    );
  end

  assign mix_l     = y_a[0];
  assign mix_r     = y_a[1];
  assign out_valid = v_stage[LAT-1];
endmodule

// File: rtl/xfade_mixer_chk.sv
module xfade_mixer_chk #(
  parameter int DW = 16,
  parameter int WW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 xfade_en,
  input logic                 rev_play,
  input logic        [WW-1:0] weight,
  input logic signed [DW-1:0] rev_l,
  input logic signed [DW-1:0] rev_r,
  input logic signed [DW-1:0] fwd_l,
  input logic signed [DW-1:0] fwd_r,
  input logic                 out_valid,
  input logic signed [DW-1:0] mix_l,
  input logic signed [DW-1:0] mix_r
);
  // two-deep record of the frame inputs, aligned with the result
  logic                 v1, v2, x1, x2, p1, p2;
  logic signed [DW-1:0] rl1, rl2, fl1, fl2, rr1, rr2, fr1, fr2;
  logic signed [DW+1:0] rl2_w, ml_w;
  logic                 unused_w;

  assign unused_w = ^weight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; x1 <= 1'b0; x2 <= 1'b0; p1 <= 1'b0; p2 <= 1'b0;
      rl1 <= '0; rl2 <= '0; fl1 <= '0; fl2 <= '0;
      rr1 <= '0; rr2 <= '0; fr1 <= '0; fr2 <= '0;
    end else begin
      v1 <= in_valid; v2 <= v1;
      x1 <= xfade_en; x2 <= x1;
      p1 <= rev_play; p2 <= p1;
      rl1 <= rev_l; rl2 <= rl1;
      fl1 <= fwd_l; fl2 <= fl1;
      rr1 <= rev_r; rr2 <= rr1;
      fr1 <= fwd_r; fr2 <= fr1;
    end
  end

  assign rl2_w = {{2{rl2[DW-1]}}, rl2};
  assign ml_w  = {{2{mix_l[DW-1]}}, mix_l};

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2); // R8

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(mix_l) && $stable(mix_r))); // R9

  AST_PASS_REV: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !x2 && p2) |-> (mix_l == rl2 && mix_r == rr2)); // R4

  AST_PASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !x2 && !p2) |-> (mix_l == fl2 && mix_r == fr2)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && x2 && rl2 == fl2) |-> (ml_w <= rl2_w && ml_w >= rl2_w - 1)); // R7

  always_comb begin
    if (!rst_n) begin
      AST_RESET_OUT: assert (!out_valid); // R10
    end
  end
endmodule

bind xfade_mixer xfade_mixer_chk #(.DW(DW), .WW(WW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xfade_en(xfade_en),
  .rev_play(rev_play), .weight(weight), .rev_l(rev_l), .rev_r(rev_r),
  .fwd_l(fwd_l), .fwd_r(fwd_r), .out_valid(out_valid),
  .mix_l(mix_l), .mix_r(mix_r)
);

// File: tb/sim_xfade_mixer.sv
module sim_xfade_mixer;
  logic               clk;
  logic               rst_n;
  logic               in_valid, xfade_en, rev_play;
  logic        [15:0] weight;
  logic signed [15:0] rev_l, rev_r, fwd_l, fwd_r;
  logic               out_valid;
  logic signed [15:0] mix_l, mix_r;

  int errors = 0;
  int checks = 0;

  xfade_mixer u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xfade_en(xfade_en),
    .rev_play(rev_play), .weight(weight), .rev_l(rev_l), .rev_r(rev_r),
    .fwd_l(fwd_l), .fwd_r(fwd_r), .out_valid(out_valid),
    .mix_l(mix_l), .mix_r(mix_r)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NV = 8;
  localparam logic signed [15:0] T_RL [NV] = '{16'sd1000, 16'sd1000, -16'sd32768, 16'sd32767,
                                              -16'sd300, 16'sd12345, 16'sd12345, -16'sd32768};
  localparam logic signed [15:0] T_FL [NV] = '{-16'sd2000, -16'sd2000, -16'sd32768, 16'sd32767,
                                              16'sd700, -16'sd1, -16'sd1, 16'sd32767};
  localparam logic signed [15:0] T_RR [NV] = '{-16'sd5, 16'sd77, 16'sd32767, -16'sd32768,
                                              -16'sd9999, -16'sd42, -16'sd42, 16'sd1};
  localparam logic signed [15:0] T_FR [NV] = '{16'sd31000, 16'sd31000, 16'sd32767, -16'sd32768,
                                              -16'sd1, 16'sd88, 16'sd88, -16'sd1};
  localparam logic [15:0] T_W [NV] = '{16'hFFFF, 16'h0000, 16'h8000, 16'h1234,
                                       16'h7F80, 16'h5555, 16'h5555, 16'h0080};
  localparam bit T_X [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam bit T_P [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  function automatic logic signed [15:0] ref_out(input logic signed [15:0] r,
      input logic signed [15:0] f, input logic [15:0] w, input bit x, input bit p);
    longint acc;
    if (!x) return p ? r : f;
    acc = longint'(r) * longint'({48'd0, w}) + longint'(f) * (65535 - longint'({48'd0, w}));
    return 16'(acc >>> 16);
  endfunction

  task automatic check16(input string req, input logic signed [15:0] act,
                         input logic signed [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input int i, input bit v);
    in_valid = v; xfade_en = T_X[i]; rev_play = T_P[i]; weight = T_W[i];
    rev_l = T_RL[i]; fwd_l = T_FL[i]; rev_r = T_RR[i]; fwd_r = T_FR[i];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    check1("R10 out_valid in reset", out_valid, 1'b0);
    check16("R10 mix_l in reset", mix_l, 16'sd0);
    check16("R10 mix_r in reset", mix_r, 16'sd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(i, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check1("R8 no early valid", out_valid, 1'b0);
      @(negedge clk);
      check1("R8 valid at latency 2", out_valid, 1'b1);
      check16("R1 R2 R3 R4 R5 R6 R7 left", mix_l,
              ref_out(T_RL[i], T_FL[i], T_W[i], T_X[i], T_P[i]));
      check16("R1 R2 R3 R4 R5 R6 R7 right", mix_r,
              ref_out(T_RR[i], T_FR[i], T_W[i], T_X[i], T_P[i]));
      @(negedge clk);
      check1("R8 single pulse", out_valid, 1'b0);
    end

    // R3: explicit endpoint values
    drive(0, 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check16("R3 weight ffff", mix_l, 16'sd999);
    drive(1, 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check16("R3 weight 0000", mix_l, -16'sd2000);
    // R7: full-scale negative on both sources
    drive(2, 1'b1); @(negedge clk); in_valid = 1'b0; @(negedge clk);
    check16("R7 full negative", mix_l, -16'sd32768);
    check16("R7 full positive", mix_r, 16'sd32766);

    // R9: inputs change without strobe, outputs hold
    drive(4, 1'b0);
    repeat (4) @(negedge clk);
    check16("R9 hold left", mix_l, -16'sd32768);
    check16("R9 hold right", mix_r, 16'sd32766);
    check1("R9 no strobe", out_valid, 1'b0);

    // R11: back-to-back frames in mixed modes
    drive(4, 1'b1); @(negedge clk);
    drive(5, 1'b1); @(negedge clk);
    drive(6, 1'b1);
    check1("R11 valid frame 4", out_valid, 1'b1);
    check16("R11 frame 4 left", mix_l, ref_out(T_RL[4], T_FL[4], T_W[4], 1'b1, 1'b0));
    @(negedge clk);
    in_valid = 1'b0;
    check16("R11 frame 5 left", mix_l, T_RL[5]);
    check16("R11 frame 5 right", mix_r, T_RR[5]);
    @(negedge clk);
    check1("R11 valid frame 6", out_valid, 1'b1);
    check16("R11 frame 6 left", mix_l, T_FL[6]);
    check16("R11 frame 6 right", mix_r, T_FR[6]);
    @(negedge clk);
    check1("R11 pipeline drained", out_valid, 1'b0);

    // R10: reset mid-run with a frame in flight
    drive(3, 1'b1); @(negedge clk); in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check1("R10 valid cleared", out_valid, 1'b0);
    check16("R10 left cleared", mix_l, 16'sd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check1("R10 flushed frame", out_valid, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule